// File: doc/BRIEF.md
# Dual-Axis Stepper Pulse Generator

This block drives two independent stepper axes, a transverse axis (index 0) and a longitudinal axis (index 1). For each axis, firmware writes a velocity, a target step count, an interrupt step and a small control word over a simple write port. The block then issues micro-step pulses at the programmed spacing until the number of pulses issued equals the target. A readable progress count and a zero-count flag report how far the move has gone.

Spacing is counted in ticks of a base clock. The base clock comes from a divider, and its default divide ratio gives 2 MHz from a 100 MHz system clock. Pulses on an axis are held back while the axis is disabled. They are also held back while the limit switch facing the current direction is closed, unless that axis's override bit is set. Each axis has a sticky interrupt flag. The flag is raised when a pulse reaches the programmed interrupt step, or on every pulse when acceleration mode is on, so that firmware can reload the velocity and ramp the speed.

A motor-power enable output is forced off while scanner reset is asserted.

Top module: `stepgen_dual`

## Requirements
- R1: After reset, every axis shows step low, interrupt low, progress 0, zero flag high and direction bit 0. With default parameters all control bits are clear.
- R2: Writing the target register (wr_sel=1) clears progress and starts a move. The first pulse rises on the next base tick. Progress rises by one on each pulse, and pulsing stops once progress equals the target. A target of 0 issues no pulse.
- R3: Consecutive rising edges of step are max(velocity, PULSE_W+1) base ticks apart. The velocity is set with wr_sel=0.
- R4: Each step pulse stays high for exactly PULSE_W base ticks (default 4).
- R5: A velocity write during a move leaves the interval already started unchanged. The new value governs the interval that begins at the next pulse.
- R6: While the enable bit (control bit 0; control is wr_sel=3) is 0, no pulse is issued. The move holds and resumes when the bit is set again.
- R7: dir_n_o equals control bit 1 (0 = forward). A closed forward limit blocks pulses while the direction is forward, and a closed reverse limit blocks them while it is reverse. The limit facing away from the direction has no effect. With override (control bit 2) set, neither limit blocks.
- R8: The interrupt flag sets on the pulse that makes progress equal to the interrupt-step register (wr_sel=2), and not on earlier pulses.
- R9: With acceleration mode (control bit 3) set, the interrupt flag sets on every pulse.
- R10: The interrupt flag stays set until a control write with bit 4 = 1 clears it. If that clearing write lands in the same cycle as a pulse that sets the flag, the flag ends set.
- R11: zero_o is 1 exactly when the axis's progress count is 0.
- R12: motor_power_n (active low) follows pwr_n_req, except that it is 1 whenever scan_reset is 1.
- R13: Writes carry an axis select (wr_axis: 0 transverse, 1 longitudinal). A move on one axis leaves the other axis's pulses and progress untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_reset | input | 1 | Scanner reset; forces motor power off |
| pwr_n_req | input | 1 | Requested motor power, active low |
| wr_en | input | 1 | Register write strobe |
| wr_axis | input | 1 | Axis select for the write |
| wr_sel | input | 2 | 0 velocity, 1 target, 2 interrupt step, 3 control |
| wr_data | input | REG_W | Write data |
| lim_fwd_i | input | 2 | Forward limit switch closed, per axis |
| lim_rev_i | input | 2 | Reverse limit switch closed, per axis |
| step_o | output | 2 | Micro-step pulse, per axis |
| dir_n_o | output | 2 | Direction, 0 = forward, per axis |
| irq_o | output | 2 | Sticky interrupt flag, per axis |
| zero_o | output | 2 | Progress count equals zero, per axis |
| pos_o | output | 2 x REG_W | Progress count, per axis |
| motor_power_n | output | 1 | Motor power enable, active low |

## Verification
The interrupt flag has a setter and a clearer, and both can act in the same cycle: a pulse that raises the flag and a control write that clears it. The bench sets up this collision on purpose. It writes a target, which makes the first pulse issue on the following edge, and in that same following cycle it writes a control word that has both the clear bit and acceleration mode set. The bench then checks that progress reads 1 and the flag reads 1. A later clearing write, with no pulse in its cycle, must bring the flag back to 0.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2
    } axis_state_t;

    localparam logic [1:0] SEL_VEL = 2'd0;
    localparam logic [1:0] SEL_TGT = 2'd1;
    localparam logic [1:0] SEL_IRQ = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    localparam int CTL_EN    = 0;
    localparam int CTL_FWD_N = 1;
    localparam int CTL_OVR   = 2;
    localparam int CTL_ACC   = 3;
    localparam int CTL_CLR   = 4;
endpackage

// File: rtl/stepgen_tick.sv
module stepgen_tick #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (TICK_DIV <= 1) begin : g_bypass
            logic run_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) run_q <= 1'b0;
                else        run_q <= 1'b1;
            end
            assign tick_o = run_q;
        end else begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              div_q <= '0;
                else if (div_q == LAST)  div_q <= '0;
                else                     div_q <= div_q + 1'b1;
            end
            assign tick_o = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/stepgen_axis.sv
module stepgen_axis
    import stepgen_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int PULSE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             lim_fwd,
    input  logic             lim_rev,
    output logic             step_o,
    output logic             dir_n_o,
    output logic             irq_o,
    output logic             zero_o,
    output logic [REG_W-1:0] pos_o
);
    localparam int PW_W    = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
    localparam int MIN_PER = PULSE_W + 1;

    axis_state_t      state_q, state_d;
    logic [REG_W-1:0] vel_q, tgt_q, irs_q, cnt_q, tmr_q, per_eff, cnt_nx;
    logic [PW_W-1:0]  pw_q;
    logic             en_q, fwdn_q, ovr_q, acc_q, irq_q;
    logic             wr_vel, wr_tgt, wr_irs, wr_ctl;
    logic             blocked, issue;

    assign wr_vel = wr_en && (wr_sel == SEL_VEL);
    assign wr_tgt = wr_en && (wr_sel == SEL_TGT);
    assign wr_irs = wr_en && (wr_sel == SEL_IRQ);
    assign wr_ctl = wr_en && (wr_sel == SEL_CTL);

    // Limit facing the travel direction stops pulses unless overridden.
    assign blocked = !ovr_q && (fwdn_q ? lim_rev : lim_fwd);
    assign per_eff = (vel_q < REG_W'(MIN_PER)) ? REG_W'(MIN_PER) : vel_q;
    assign cnt_nx  = cnt_q + 1'b1;
    assign issue   = tick && (state_q == ST_WAIT) && (cnt_q != tgt_q)
                     && (tmr_q == '0) && en_q && !blocked;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (wr_tgt) begin
            state_d = (wr_data == '0) ? ST_IDLE : ST_WAIT;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_WAIT: begin
                    if (cnt_q == tgt_q) state_d = ST_IDLE;
                    else if (issue)     state_d = ST_PULSE;
                end
                ST_PULSE: if (pw_q == '0) state_d = ST_WAIT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vel_q   <= '0;
            tgt_q   <= '0;
            irs_q   <= '0;
            cnt_q   <= '0;
            tmr_q   <= '0;
            pw_q    <= '0;
            en_q    <= 1'b0;
            fwdn_q  <= 1'b0;
            ovr_q   <= 1'b0;
            acc_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (wr_vel) vel_q <= wr_data;
            if (wr_irs) irs_q <= wr_data;
            if (wr_ctl) begin
                en_q   <= wr_data[CTL_EN];
                fwdn_q <= wr_data[CTL_FWD_N];
                ovr_q  <= wr_data[CTL_OVR];
                acc_q  <= wr_data[CTL_ACC];
            end
            if (wr_tgt) begin
                tgt_q <= wr_data;
                cnt_q <= '0;
                tmr_q <= '0;
            end else if (issue) begin
                cnt_q <= cnt_nx;
                tmr_q <= per_eff - 1'b1;
                pw_q  <= PW_W'(PULSE_W - 1);
            end else if (tick) begin
                if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
                if (state_q == ST_PULSE && pw_q != '0) pw_q <= pw_q - 1'b1;
            end
            // Setting takes priority over a simultaneous clear.
            if (issue && (acc_q || cnt_nx == irs_q)) irq_q <= 1'b1;
            else if (wr_ctl && wr_data[CTL_CLR])     irq_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        step_o  = (state_q == ST_PULSE);
        dir_n_o = fwdn_q;
        irq_o   = irq_q;
        zero_o  = (cnt_q == '0);
        pos_o   = cnt_q;
    end
endmodule

// File: rtl/stepgen_dual.sv
module stepgen_dual
    import stepgen_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int PULSE_W  = 4,
    parameter int TICK_DIV = 50
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scan_reset,
    input  logic                       pwr_n_req,
    input  logic                       wr_en,
    input  logic                       wr_axis,
    input  logic [1:0]                 wr_sel,
    input  logic [REG_W-1:0]           wr_data,
    input  logic [1:0]                 lim_fwd_i,
    input  logic [1:0]                 lim_rev_i,
    output logic [1:0]                 step_o,
    output logic [1:0]                 dir_n_o,
    output logic [1:0]                 irq_o,
    output logic [1:0]                 zero_o,
    output logic [1:0][REG_W-1:0]      pos_o,
    output logic                       motor_power_n
);
    localparam int NAX = 2;

    logic tick;

    stepgen_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar a = 0; a < NAX; a++) begin : g_ax
        stepgen_axis #(.REG_W(REG_W), .PULSE_W(PULSE_W)) u_axis (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .wr_en   (wr_en && (wr_axis == 1'(a))),
            .wr_sel  (wr_sel),
            .wr_data (wr_data),
            .lim_fwd (lim_fwd_i[a]),
            .lim_rev (lim_rev_i[a]),
            .step_o  (step_o[a]),
            .dir_n_o (dir_n_o[a]),
            .irq_o   (irq_o[a]),
            .zero_o  (zero_o[a]),
            .pos_o   (pos_o[a])
        );
    end

    assign motor_power_n = scan_reset | pwr_n_req;
endmodule

// File: rtl/stepgen_chk.sv
module stepgen_chk #(
    parameter int REG_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scan_reset,
    input logic                  motor_power_n,
    input logic                  wr_en,
    input logic                  wr_axis,
    input logic [1:0]            wr_sel,
    input logic                  ctl_en_bit,
    input logic                  ctl_ovr_bit,
    input logic [1:0]            lim_fwd_i,
    input logic [1:0]            lim_rev_i,
    input logic [1:0]            step_o,
    input logic [1:0]            dir_n_o,
    input logic [1:0]            irq_o,
    input logic [1:0][REG_W-1:0] pos_o
);
    assert_power_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        scan_reset |-> motor_power_n);

    for (genvar a = 0; a < 2; a++) begin : g_chk
        logic en_sh, ovr_sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_sh  <= 1'b0;
                ovr_sh <= 1'b0;
            end else if (wr_en && wr_axis == 1'(a) && wr_sel == 2'd3) begin
                en_sh  <= ctl_en_bit;
                ovr_sh <= ctl_ovr_bit;
            end
        end

        assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(step_o[a]) |-> $past(en_sh));

        assert_limit_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(step_o[a]) |-> ($past(ovr_sh) ||
                !(($past(dir_n_o[a]) == 1'b0 && $past(lim_fwd_i[a])) ||
                  ($past(dir_n_o[a]) == 1'b1 && $past(lim_rev_i[a])))));

        assert_count_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(step_o[a]) |-> (pos_o[a] == REG_W'($past(pos_o[a]) + 1'b1)));

        assert_pos_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pos_o[a] != $past(pos_o[a])) |->
                (pos_o[a] == '0 || pos_o[a] == REG_W'($past(pos_o[a]) + 1'b1)));

        assert_irq_on_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[a]) |-> $rose(step_o[a]));
    end
endmodule

bind stepgen_dual stepgen_chk #(.REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scan_reset    (scan_reset),
    .motor_power_n (motor_power_n),
    .wr_en         (wr_en),
    .wr_axis       (wr_axis),
    .wr_sel        (wr_sel),
    .ctl_en_bit    (wr_data[0]),
    .ctl_ovr_bit   (wr_data[2]),
    .lim_fwd_i     (lim_fwd_i),
    .lim_rev_i     (lim_rev_i),
    .step_o        (step_o),
    .dir_n_o       (dir_n_o),
    .irq_o         (irq_o),
    .pos_o         (pos_o)
);

// File: tb/tb_stepgen_dual.sv
`timescale 1ns/1ps
module tb_stepgen_dual;
    localparam int REG_W = 16;
    localparam int PW    = 4;
    localparam int MAXR  = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_reset = 1'b1;
    logic pwr_n_req = 1'b0;
    logic wr_en = 1'b0;
    logic wr_axis = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [REG_W-1:0] wr_data = '0;
    logic [1:0] lim_fwd_i = 2'b00;
    logic [1:0] lim_rev_i = 2'b00;
    logic [1:0] step_o, dir_n_o, irq_o, zero_o;
    logic [1:0][REG_W-1:0] pos_o;
    logic motor_power_n;

    stepgen_dual #(.REG_W(REG_W), .PULSE_W(PW), .TICK_DIV(1)) dut (
        .clk(clk), .rst_n(rst_n), .scan_reset(scan_reset), .pwr_n_req(pwr_n_req),
        .wr_en(wr_en), .wr_axis(wr_axis), .wr_sel(wr_sel), .wr_data(wr_data),
        .lim_fwd_i(lim_fwd_i), .lim_rev_i(lim_rev_i), .step_o(step_o),
        .dir_n_o(dir_n_o), .irq_o(irq_o), .zero_o(zero_o), .pos_o(pos_o),
        .motor_power_n(motor_power_n)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rise_t [2][MAXR];
    int fall_t [2][MAXR];
    int rise_n [2] = '{0, 0};
    int fall_n [2] = '{0, 0};
    logic [1:0] prev_step = 2'b00;

    // Edge recorder, sampling 2 ns after each rising clock edge
    always @(posedge clk) begin
        #2;
        cyc++;
        for (int a = 0; a < 2; a++) begin
            if (step_o[a] && !prev_step[a]) begin
                if (rise_n[a] < MAXR) rise_t[a][rise_n[a]] = cyc;
                rise_n[a]++;
            end
            if (!step_o[a] && prev_step[a]) begin
                if (fall_n[a] < MAXR) fall_t[a][fall_n[a]] = cyc;
                fall_n[a]++;
            end
            prev_step[a] = step_o[a];
        end
        if (cyc > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge; the write lands on the next rising edge.
    task automatic wr(input int ax, input int sel, input int data);
        wr_en   = 1'b1;
        wr_axis = 1'(ax);
        wr_sel  = 2'(sel);
        wr_data = REG_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_pos(input int ax, input int val);
        for (int i = 0; i < 2000; i++) begin
            if (int'(pos_o[ax]) == val) break;
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        for (int a = 0; a < 2; a++) begin
            chk(step_o[a] == 1'b0, "R1", "step after reset", int'(step_o[a]), 0);
            chk(irq_o[a] == 1'b0, "R1", "irq after reset", int'(irq_o[a]), 0);
            chk(int'(pos_o[a]) == 0, "R1", "progress after reset", int'(pos_o[a]), 0);
            chk(zero_o[a] == 1'b1, "R11", "zero flag after reset", int'(zero_o[a]), 1);
            chk(dir_n_o[a] == 1'b0, "R1", "direction after reset", int'(dir_n_o[a]), 0);
        end
    endtask

    task automatic test_basic_move();
        int rb;
        wr(0, 3, 'h01);
        wr(0, 0, 10);
        rb = rise_n[0];
        wr(0, 1, 5);
        chk(step_o[0] == 1'b0, "R2", "step in write cycle", int'(step_o[0]), 0);
        @(negedge clk);
        chk(step_o[0] == 1'b1, "R2", "first pulse next tick", int'(step_o[0]), 1);
        chk(int'(pos_o[0]) == 1, "R2", "progress after first pulse", int'(pos_o[0]), 1);
        idle(80);
        chk(int'(pos_o[0]) == 5, "R2", "progress at end of move", int'(pos_o[0]), 5);
        chk(rise_n[0] - rb == 5, "R2", "pulses in move", rise_n[0] - rb, 5);
        chk(zero_o[0] == 1'b0, "R11", "zero flag after move", int'(zero_o[0]), 0);
        for (int k = 1; k < 5; k++)
            chk(rise_t[0][rb+k] - rise_t[0][rb+k-1] == 10, "R3", "pulse spacing vel=10",
                rise_t[0][rb+k] - rise_t[0][rb+k-1], 10);
        for (int k = 0; k < 5; k++)
            chk(fall_t[0][rb+k] - rise_t[0][rb+k] == PW, "R4", "pulse width",
                fall_t[0][rb+k] - rise_t[0][rb+k], PW);
    endtask

    task automatic test_min_period();
        int rb;
        wr(0, 0, 2);
        rb = rise_n[0];
        wr(0, 1, 3);
        idle(40);
        chk(rise_n[0] - rb == 3, "R3", "pulses at short velocity", rise_n[0] - rb, 3);
        for (int k = 1; k < 3; k++)
            chk(rise_t[0][rb+k] - rise_t[0][rb+k-1] == PW + 1, "R3", "clamped spacing",
                rise_t[0][rb+k] - rise_t[0][rb+k-1], PW + 1);
    endtask

    task automatic test_ramp();
        int rb;
        wr(0, 0, 20);
        rb = rise_n[0];
        wr(0, 1, 4);
        for (int i = 0; i < 100; i++) begin
            if (rise_n[0] > rb) break;
            @(negedge clk);
        end
        wr(0, 0, 8);
        idle(80);
        chk(rise_n[0] - rb == 4, "R5", "pulses in ramped move", rise_n[0] - rb, 4);
        chk(rise_t[0][rb+1] - rise_t[0][rb] == 20, "R5", "interval in progress keeps old velocity",
            rise_t[0][rb+1] - rise_t[0][rb], 20);
        chk(rise_t[0][rb+2] - rise_t[0][rb+1] == 8, "R5", "next interval uses new velocity",
            rise_t[0][rb+2] - rise_t[0][rb+1], 8);
        chk(rise_t[0][rb+3] - rise_t[0][rb+2] == 8, "R5", "later interval uses new velocity",
            rise_t[0][rb+3] - rise_t[0][rb+2], 8);
    endtask

    task automatic test_enable();
        int rb;
        wr(0, 3, 'h00);
        rb = rise_n[0];
        wr(0, 1, 3);
        idle(40);
        chk(int'(pos_o[0]) == 0, "R6", "progress while disabled", int'(pos_o[0]), 0);
        chk(rise_n[0] == rb, "R6", "pulses while disabled", rise_n[0] - rb, 0);
        wr(0, 3, 'h01);
        idle(60);
        chk(int'(pos_o[0]) == 3, "R6", "move resumes after enable", int'(pos_o[0]), 3);
    endtask

    task automatic test_limits();
        wr(0, 0, 6);
        lim_fwd_i[0] = 1'b1;
        wr(0, 3, 'h01);
        wr(0, 1, 2);
        idle(30);
        chk(int'(pos_o[0]) == 0, "R7", "forward limit blocks forward move", int'(pos_o[0]), 0);
        wr(0, 3, 'h05);
        idle(30);
        chk(int'(pos_o[0]) == 2, "R7", "override passes forward limit", int'(pos_o[0]), 2);
        lim_rev_i[0] = 1'b1;
        wr(0, 3, 'h03);
        chk(dir_n_o[0] == 1'b1, "R7", "direction bit reverse", int'(dir_n_o[0]), 1);
        wr(0, 1, 2);
        idle(30);
        chk(int'(pos_o[0]) == 0, "R7", "reverse limit blocks reverse move", int'(pos_o[0]), 0);
        lim_rev_i[0] = 1'b0;
        idle(30);
        chk(int'(pos_o[0]) == 2, "R7", "forward limit ignored in reverse", int'(pos_o[0]), 2);
        lim_fwd_i[0] = 1'b0;
        wr(0, 3, 'h01);
        chk(dir_n_o[0] == 1'b0, "R7", "direction bit forward", int'(dir_n_o[0]), 0);
    endtask

    task automatic test_irq_step();
        wr(0, 3, 'h11);
        wr(0, 2, 3);
        wr(0, 0, 12);
        wr(0, 1, 5);
        wait_pos(0, 2);
        chk(irq_o[0] == 1'b0, "R8", "irq before programmed step", int'(irq_o[0]), 0);
        wait_pos(0, 3);
        chk(irq_o[0] == 1'b1, "R8", "irq at programmed step", int'(irq_o[0]), 1);
        idle(60);
        chk(irq_o[0] == 1'b1, "R10", "irq sticky after move", int'(irq_o[0]), 1);
        wr(0, 3, 'h11);
        chk(irq_o[0] == 1'b0, "R10", "irq cleared by write", int'(irq_o[0]), 0);
    endtask

    task automatic test_accel();
        wr(0, 3, 'h19);
        wr(0, 2, 0);
        wr(0, 0, 30);
        wr(0, 1, 3);
        wait_pos(0, 1);
        chk(irq_o[0] == 1'b1, "R9", "irq on first pulse in accel mode", int'(irq_o[0]), 1);
        wr(0, 3, 'h19);
        chk(irq_o[0] == 1'b0, "R9", "irq cleared between pulses", int'(irq_o[0]), 0);
        wait_pos(0, 2);
        chk(irq_o[0] == 1'b1, "R9", "irq on second pulse in accel mode", int'(irq_o[0]), 1);
        idle(70);
    endtask

    task automatic test_collision();
        wr(0, 3, 'h19);
        wr(0, 0, 30);
        wr(0, 1, 3);
        wr(0, 3, 'h19);
        chk(int'(pos_o[0]) == 1, "R10", "pulse issued in clear cycle", int'(pos_o[0]), 1);
        chk(irq_o[0] == 1'b1, "R10", "set wins over same-cycle clear", int'(irq_o[0]), 1);
        wr(0, 3, 'h19);
        chk(irq_o[0] == 1'b0, "R10", "clear without pulse", int'(irq_o[0]), 0);
        idle(70);
    endtask

    task automatic test_zero_target();
        int rb;
        chk(zero_o[0] == 1'b0, "R11", "zero flag low with progress", int'(zero_o[0]), 0);
        rb = rise_n[0];
        wr(0, 1, 0);
        chk(zero_o[0] == 1'b1, "R11", "zero flag after retarget", int'(zero_o[0]), 1);
        idle(20);
        chk(rise_n[0] == rb, "R2", "no pulse for target 0", rise_n[0] - rb, 0);
    endtask

    task automatic test_power();
        scan_reset = 1'b0;
        pwr_n_req  = 1'b0;
        @(negedge clk);
        chk(motor_power_n == 1'b0, "R12", "power follows request", int'(motor_power_n), 0);
        scan_reset = 1'b1;
        @(negedge clk);
        chk(motor_power_n == 1'b1, "R12", "power forced off in scanner reset", int'(motor_power_n), 1);
        scan_reset = 1'b0;
        pwr_n_req  = 1'b1;
        @(negedge clk);
        chk(motor_power_n == 1'b1, "R12", "power off by request", int'(motor_power_n), 1);
    endtask

    task automatic test_independent();
        int p0, r0;
        p0 = int'(pos_o[0]);
        r0 = rise_n[0];
        wr(1, 3, 'h03);
        chk(dir_n_o[1] == 1'b1, "R13", "long axis direction", int'(dir_n_o[1]), 1);
        chk(dir_n_o[0] == 1'b0, "R13", "trans direction untouched", int'(dir_n_o[0]), 0);
        wr(1, 0, 7);
        wr(1, 1, 4);
        idle(50);
        chk(int'(pos_o[1]) == 4, "R13", "long axis progress", int'(pos_o[1]), 4);
        chk(int'(pos_o[0]) == p0, "R13", "trans progress untouched", int'(pos_o[0]), p0);
        chk(rise_n[0] == r0, "R13", "no trans pulses", rise_n[0] - r0, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        test_reset();
        test_power();
        test_basic_move();
        test_min_period();
        test_ramp();
        test_enable();
        test_limits();
        test_irq_step();
        test_accel();
        test_collision();
        test_zero_target();
        test_independent();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule